// File: doc/BRIEF.md
# Write-Only Serial Volume Register Slave

This block is the control-side front end of a stereo speaker amplifier. It listens to a two-wire serial bus (I2C), picks out write transfers addressed to it, and keeps one command register that holds a 6-bit speaker volume level and a choice between filterless and classic PWM output modulation. It only receives. It drives the data line solely through an open-drain pull-down enable, and only to acknowledge.

SCL and SDA are oversampled on the system clock. Each passes through a synchronizer and a glitch filter, and bus conditions are decoded from the filtered lines. The device address is fixed except for its two low bits, which come from two strap pins. When both straps are low, the serial interface is off and the block reports that volume is set by the analog path. While the shutdown input is low, the register returns to its default and the bus is ignored.

Top module: `vol_i2c_slave`

## Requirements
- R1: The 7-bit address is 1,0,0,1,0 then strap_hi then strap_lo, sent MSB first and followed by R/W = 0. The block acknowledges a matching address byte, for example 0x94 with strap_hi=1 and strap_lo=0, or 0x96 with both straps high.
- R2: An address byte that does not match, or that has R/W = 1, is not acknowledged. Bytes that follow it are not acknowledged before the next START, and the register is left unchanged.
- R3: With both straps low, analog_mode is 1 and the block never asserts sda_pull.
- R4: An acknowledge holds sda_pull high through the whole high phase of the 9th clock. sda_pull is released after that clock falls and is low at all other times.
- R5: An acknowledged data byte of the form 00vvvvvv loads v (0 to 63) into volume. Level 0 is full mute.
- R6: An acknowledged data byte of the form 01xxxxxm sets pwm_classic to m (1 = classic PWM, 0 = filterless) and leaves volume unchanged.
- R7: A data byte with prefix 10 or 11 is acknowledged but changes neither volume nor pwm_classic.
- R8: update_pulse is high for exactly one clock after the falling edge of the data byte's acknowledge clock, once for each acknowledged data byte. It does not pulse during that clock's high phase.
- R9: A STOP at any point in a transfer aborts it. A data byte cut short by a STOP updates nothing.
- R10: A repeated START restarts address matching, so a write that follows a rejected address in the same bus session succeeds.
- R11: After reset, and while shdn_n is low, volume is 40 and pwm_classic is 0. While shdn_n is low, nothing is acknowledged.
- R12: A low pulse on SCL shorter than FILT_CYCLES system clocks is ignored.
- R13: A STOP that falls in the same SCL high pulse as the START before it is ignored, and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Low = device shut down, register cleared |
| strap_hi | input | 1 | Upper strap bit of the address |
| strap_lo | input | 1 | Lower strap bit of the address |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| analog_mode | output | 1 | Straps select analog volume; serial interface off |
| volume | output | 6 | Volume level, 0 = full mute |
| pwm_classic | output | 1 | 1 = classic PWM, 0 = filterless modulation |
| update_pulse | output | 1 | One-clock strobe after a data byte is acknowledged |

## Verification
The bench targets the places where a slave like this usually goes wrong. A STOP placed in the same high pulse as the START would make a naive decoder drop a valid write. A STOP in the middle of a data byte would make a loose design commit half a byte. A runt SCL pulse inside a bit would shift an extra bit in and load the wrong volume. After a rejected address, a repeated START must bring back address matching, or the write that follows is lost. The bench also checks the following. The acknowledge must stay low across the whole 9th high phase, or the master sees a NACK. The unused prefixes and the modulation code must leave the volume alone. With straps set to analog, or with shutdown low, the block must not acknowledge, and a design that missed this would corrupt a bus shared with other devices.

// File: rtl/vol_i2c_pkg.sv
package vol_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int VOL_W  = 6;
  localparam int PFX_W  = BYTE_W - VOL_W;
  localparam logic [4:0]       DEV_PREFIX = 5'b10010;
  localparam logic [PFX_W-1:0] CMD_VOLUME = 2'b00;
  localparam logic [PFX_W-1:0] CMD_MODSEL = 2'b01;
  localparam logic [VOL_W-1:0] VOL_RESET  = 6'd40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/vol_i2c_deglitch.sv
module vol_i2c_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_cnt;
  logic                   raw;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  assign raw = sync_q[SYNC_STAGES-1];

  // The filtered level follows only after the new level has persisted.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      line_out <= 1'b1;
    end else if (raw == line_out) begin
      run_cnt <= '0;
    end else if (run_cnt == CNT_LAST) begin
      line_out <= raw;
      run_cnt  <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vol_i2c_cond.sv
module vol_i2c_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/vol_i2c_fsm.sv
module vol_i2c_fsm
  import vol_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        strap,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_f,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

  bus_state_t        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              start_hi;  // START seen in the current SCL high pulse
  logic [BYTE_W-1:0] own_addr;

  assign own_addr = {DEV_PREFIX, strap, 1'b0};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      start_hi <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        start_hi <= 1'b1;
      end else if (stop_det && !start_hi) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        if (scl_fall) start_hi <= 1'b0;
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bit_cnt < BITS_FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BITS_FULL) begin
              if (state == ST_DATA) begin
                sda_pull <= 1'b1;
                state    <= ST_DATA_ACK;
              end else if (shreg == own_addr) begin
                sda_pull <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              wr_en    <= 1'b1;
              wr_data  <= shreg;
              state    <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vol_i2c_cmdreg.sv
module vol_i2c_cmdreg
  import vol_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [VOL_W-1:0]  volume,
  output logic              pwm_classic,
  output logic              update_pulse
);
  logic [PFX_W-1:0] prefix;
  assign prefix = wr_data[BYTE_W-1 -: PFX_W];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      volume       <= VOL_RESET;
      pwm_classic  <= 1'b0;
      update_pulse <= 1'b0;
    end else begin
      update_pulse <= wr_en;
      if (wr_en) begin
        if (prefix == CMD_VOLUME)      volume      <= wr_data[VOL_W-1:0];
        else if (prefix == CMD_MODSEL) pwm_classic <= wr_data[0];
      end
    end
  end
endmodule

// File: rtl/vol_i2c_slave.sv
module vol_i2c_slave
  import vol_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shdn_n,
  input  logic             strap_hi,
  input  logic             strap_lo,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic             analog_mode,
  output logic [VOL_W-1:0] volume,
  output logic             pwm_classic,
  output logic             update_pulse
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_flt;
  logic [1:0]        strap_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;

  assign line_raw = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    vol_i2c_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_flt (
      .clk     (clk),
      .rst     (rst),
      .line_in (line_raw[i]),
      .line_out(line_flt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q     <= 2'b00;
      analog_mode <= 1'b0;
    end else begin
      strap_q     <= {strap_hi, strap_lo};
      analog_mode <= ~(strap_hi | strap_lo);
    end
  end

  vol_i2c_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (line_flt[0]),
    .sda_f    (line_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  vol_i2c_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .enable   (shdn_n & ~analog_mode),
    .strap    (strap_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_f    (line_flt[1]),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  vol_i2c_cmdreg u_reg (
    .clk         (clk),
    .rst         (rst),
    .clear       (~shdn_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .volume      (volume),
    .pwm_classic (pwm_classic),
    .update_pulse(update_pulse)
  );
endmodule

// File: rtl/vol_i2c_slave_checker.sv
module vol_i2c_slave_checker (
  input logic       clk,
  input logic       rst,
  input logic       shdn_n,
  input logic       analog_mode,
  input logic       sda_pull,
  input logic [5:0] volume,
  input logic       pwm_classic,
  input logic       update_pulse
);
  assert_analog_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (analog_mode && $past(analog_mode)) |-> !sda_pull);

  assert_shutdown_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (volume == 6'd40 && !pwm_classic && !sda_pull));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    update_pulse |=> !update_pulse);

  assert_volume_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(volume) |-> (update_pulse || $past(!shdn_n)));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwm_classic) |-> (update_pulse || $past(!shdn_n)));
endmodule

bind vol_i2c_slave vol_i2c_slave_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .shdn_n      (shdn_n),
  .analog_mode (analog_mode),
  .sda_pull    (sda_pull),
  .volume      (volume),
  .pwm_classic (pwm_classic),
  .update_pulse(update_pulse)
);

// File: tb/vol_i2c_slave_test.sv
`timescale 1ns/1ps
module vol_i2c_slave_test;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, shdn_n = 1'b1, strap_hi = 1'b1, strap_lo = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, analog_mode, pwm_classic, update_pulse;
  logic [5:0] volume;
  wire  sda_line = sda_m & ~sda_pull;

  int total = 0, bad = 0, pulses = 0;
  bit finished = 0;

  vol_i2c_slave uut (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull), .analog_mode(analog_mode),
    .volume(volume), .pwm_classic(pwm_classic), .update_pulse(update_pulse)
  );

  always @(posedge clk) if (update_pulse) pulses++;

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_bit(bit b, bit glitch);
    sda_m = b; wq(); scl_m = 1;
    if (glitch) begin
      repeat (6) @(negedge clk); scl_m = 0;
      repeat (3) @(negedge clk); scl_m = 1;
      repeat (Q - 9) @(negedge clk);
    end else wq();
    wq(); scl_m = 0; wq();
  endtask

  // Sends one byte and its acknowledge clock; reports ack and checks hold/release (R4, R8).
  task automatic send_byte(logic [7:0] b, int glitch_idx, output bit ack);
    bit a_early, a_late;
    int p0;
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch_idx == i);
    sda_m = 1; wq(); scl_m = 1; p0 = pulses; wq();
    a_early = !sda_line; wq();
    a_late = !sda_line;
    check_eq("R4", "ack held whole high phase", a_late, a_early);
    check_eq("R8", "no strobe during ack high", pulses, p0);
    scl_m = 0; wq();
    check_eq("R4", "pull released after 9th clock", sda_pull, 0);
    ack = a_early;
  endtask

  task automatic write_txn(logic [7:0] adr, logic [7:0] dat, output bit ack_a, output bit ack_d);
    bus_start();
    send_byte(adr, -1, ack_a);
    ack_d = 0;
    if (ack_a) send_byte(dat, -1, ack_d);
    bus_stop();
  endtask

  task automatic t_reset();
    check_eq("R11", "volume after reset", volume, 40);
    check_eq("R11", "modulation after reset", pwm_classic, 0);
    check_eq("R3", "analog flag with straps 10", analog_mode, 0);
    check_eq("R4", "no pull at idle", sda_pull, 0);
  endtask

  task automatic t_volume();
    bit aa, ad; int p0;
    p0 = pulses;
    write_txn(8'h94, 8'h15, aa, ad);
    check_eq("R1", "address 0x94 acked", aa, 1);
    check_eq("R5", "data acked", ad, 1);
    check_eq("R5", "volume 21", volume, 21);
    check_eq("R8", "one strobe per write", pulses - p0, 1);
    write_txn(8'h94, 8'h00, aa, ad);
    check_eq("R5", "volume 0 mute", volume, 0);
    write_txn(8'h94, 8'h3F, aa, ad);
    check_eq("R5", "volume 63", volume, 63);
  endtask

  task automatic t_modsel();
    bit aa, ad;
    write_txn(8'h94, 8'h41, aa, ad);
    check_eq("R6", "classic PWM selected", pwm_classic, 1);
    check_eq("R6", "volume kept", volume, 63);
    write_txn(8'h94, 8'h40, aa, ad);
    check_eq("R6", "filterless selected", pwm_classic, 0);
  endtask

  task automatic t_unused();
    bit aa, ad; int p0;
    p0 = pulses;
    write_txn(8'h94, 8'h85, aa, ad);
    check_eq("R7", "prefix 10 acked", ad, 1);
    write_txn(8'h94, 8'hC1, aa, ad);
    check_eq("R7", "prefix 11 acked", ad, 1);
    check_eq("R7", "volume kept", volume, 63);
    check_eq("R7", "modulation kept", pwm_classic, 0);
    check_eq("R8", "strobe per acked byte", pulses - p0, 2);
  endtask

  task automatic t_mismatch();
    bit aa, ad;
    bus_start();
    send_byte(8'h96, -1, aa);
    check_eq("R2", "wrong strap bits not acked", aa, 0);
    send_byte(8'h05, -1, ad);
    check_eq("R2", "following byte not acked", ad, 0);
    bus_stop();
    write_txn(8'h95, 8'h05, aa, ad);
    check_eq("R2", "read bit not acked", aa, 0);
    check_eq("R2", "volume kept", volume, 63);
  endtask

  task automatic t_straps11();
    bit aa, ad;
    strap_lo = 1; wq();
    write_txn(8'h96, 8'h0A, aa, ad);
    check_eq("R1", "address 0x96 acked with straps 11", aa, 1);
    check_eq("R1", "volume 10", volume, 10);
    write_txn(8'h94, 8'h0B, aa, ad);
    check_eq("R2", "old address rejected", aa, 0);
    strap_lo = 0; wq();
  endtask

  task automatic t_analog();
    bit aa, ad;
    strap_hi = 0; wq();
    check_eq("R3", "analog flag", analog_mode, 1);
    write_txn(8'h90, 8'h11, aa, ad);
    check_eq("R3", "no ack in analog mode", aa, 0);
    check_eq("R3", "volume kept", volume, 10);
    strap_hi = 1; wq();
    check_eq("R3", "analog flag cleared", analog_mode, 0);
  endtask

  task automatic t_early_stop();
    bit aa, ad; int p0;
    p0 = pulses;
    bus_start();
    send_byte(8'h94, -1, aa);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bus_stop();
    check_eq("R9", "volume kept after aborted byte", volume, 10);
    check_eq("R9", "no strobe after abort", pulses - p0, 0);
    write_txn(8'h94, 8'h0C, aa, ad);
    check_eq("R9", "next write after abort", volume, 12);
  endtask

  task automatic t_rstart();
    bit aa, ad;
    bus_start();
    send_byte(8'h96, -1, aa);
    check_eq("R10", "first address rejected", aa, 0);
    bus_rstart();
    send_byte(8'h94, -1, aa);
    check_eq("R10", "address after repeated START", aa, 1);
    send_byte(8'h07, -1, ad);
    bus_stop();
    check_eq("R10", "volume 7", volume, 7);
  endtask

  task automatic t_start_stop_same();
    bit aa, ad;
    sda_m = 1; scl_m = 1; wq();
    sda_m = 0; wq(); sda_m = 1; wq();
    scl_m = 0; wq();
    send_byte(8'h94, -1, aa);
    check_eq("R13", "transfer survives stop in start pulse", aa, 1);
    send_byte(8'h22, -1, ad);
    bus_stop();
    check_eq("R13", "volume 34", volume, 34);
  endtask

  task automatic t_glitch();
    bit aa, ad;
    bus_start();
    send_byte(8'h94, -1, aa);
    send_byte(8'h2A, 3, ad);
    bus_stop();
    check_eq("R12", "runt SCL pulse ignored", volume, 42);
  endtask

  task automatic t_shutdown();
    bit aa, ad;
    shdn_n = 0; repeat (4) @(negedge clk);
    check_eq("R11", "volume in shutdown", volume, 40);
    write_txn(8'h94, 8'h09, aa, ad);
    check_eq("R11", "no ack in shutdown", aa, 0);
    shdn_n = 1; wq();
    check_eq("R11", "default after shutdown", volume, 40);
    write_txn(8'h94, 8'h05, aa, ad);
    check_eq("R11", "write after shutdown", volume, 5);
    rst = 1; repeat (3) @(negedge clk); rst = 0; wq();
    check_eq("R11", "volume after second reset", volume, 40);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0; wq();
    t_reset();
    t_volume();
    t_modsel();
    t_unused();
    t_mismatch();
    t_straps11();
    t_analog();
    t_early_stop();
    t_rstart();
    t_start_stop_same();
    t_glitch();
    t_shutdown();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule